// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block walks a chain of 8-byte descriptors held in memory and turns each one into a segment record for a downstream data mover. A start pulse latches a list base address. The walker then reads each descriptor as two 32-bit words over a request/response read port. Descriptor k sits at base + 8*k. The first word carries the segment length and an end-of-list flag, and the second word carries the segment address.

Each decoded descriptor is presented as an (address, length, last) record on a valid/ready output. The walker keeps at most one read in flight. It issues no further read while a record waits to be accepted. A walk ends when the record marked last is accepted, and the block then pulses `done_o`. If the configured number of entries has been emitted and none of them carried the last flag, the walk stops and the block pulses `err_o` instead.

Top module: `sg_list_walker`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy_o`, `rd_req_valid_o`, `seg_valid_o`, `done_o` and `err_o` are all low.
- R2: A start pulse seen while idle latches `base_i`. For descriptor k, the length word is requested at base + 8*k and the address word at base + 8*k + 4. The length word is always requested first, and the first request appears on the cycle after the start is taken.
- R3: `seg_len_o` equals bits [27:0] of the length word. Bits [30:28] of that word have no effect on any output.
- R4: `seg_addr_o` (31 bits) equals bits [30:0] of the address word. Bit 31 of that word is dropped.
- R5: `seg_last_o` equals bit 31 of the length word. When a record with that bit set is accepted, the walk ends and `done_o` is high for exactly the next cycle, with `busy_o` low in that cycle. `done_o` and `err_o` are never high together.
- R6: A record is offered only after both words of its descriptor have returned. While `seg_ready_i` is low the record's fields stay unchanged, and no read request is made.
- R7: After MAX_ENTRIES records without the last flag, the walk stops and `err_o` is high for exactly the cycle after the final record is accepted. No further read is issued until a new start.
- R8: A start pulse that arrives while a walk is in progress is ignored. The walk in progress carries on with its own base and its own sequence of read addresses.
- R9: Only one read is outstanding at a time. A read request holds `rd_req_valid_o` and keeps `rd_addr_o` stable until `rd_req_ready_i` is sampled high. A response is taken only while one is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a walk (taken only while idle) |
| base_i | input | ADDR_W | Byte address of descriptor 0 |
| rd_req_valid_o | output | 1 | Word read request valid |
| rd_req_ready_i | input | 1 | Memory accepts the request |
| rd_addr_o | output | ADDR_W | Byte address of the requested word |
| rd_rsp_valid_i | input | 1 | Read data valid |
| rd_rsp_data_i | input | 32 | Read data word |
| seg_valid_o | output | 1 | Segment record valid |
| seg_ready_i | input | 1 | Consumer accepts the record |
| seg_addr_o | output | 31 | Segment address |
| seg_len_o | output | 28 | Segment length in bytes |
| seg_last_o | output | 1 | Record is the final one of the list |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse after the last record is accepted |
| err_o | output | 1 | One-cycle pulse when the entry limit ends the walk |

## Verification
The bench builds the walker with MAX_ENTRIES = 4 and a 32-bit address. At that limit, a list without an end flag hits the limit after only four descriptors. The same setting covers a list whose end flag sits exactly on the fourth entry, which must finish with done rather than error, and a one-entry list. The bench also varies the read-ready stalls, the response latency and the record backpressure. These variations reach the hold rules on both handshakes and the case where a start arrives in the middle of a walk.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

    // Descriptor word layout (fixed by the list format)
    localparam int WORD_W      = 32;
    localparam int SEG_LEN_W   = 28;
    localparam int SEG_ADDR_W  = 31;
    localparam int END_FLAG_B  = 31;
    localparam int DESC_SHIFT  = 3;   // 8 bytes per descriptor
    localparam int WORD_SHIFT  = 2;   // 4 bytes per word

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_REQ_LEN,
        WS_WAIT_LEN,
        WS_REQ_ADR,
        WS_WAIT_ADR,
        WS_OFFER
    } walk_state_e;

endpackage

// File: rtl/sgw_addr_gen.sv
module sgw_addr_gen
    import sgw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    input  logic              word_sel,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] desc_off;
    logic [ADDR_W-1:0] word_off;

    always_comb begin
        desc_off = ADDR_W'(idx) << DESC_SHIFT;
        word_off = ADDR_W'(word_sel) << WORD_SHIFT;
        addr     = base + desc_off + word_off;
    end
endmodule

// File: rtl/sgw_field_split.sv
module sgw_field_split
    import sgw_pkg::*;
(
    input  logic [WORD_W-1:0]     len_word,
    input  logic [WORD_W-1:0]     adr_word,
    output logic [SEG_LEN_W-1:0]  seg_len,
    output logic [SEG_ADDR_W-1:0] seg_addr,
    output logic                  seg_last
);
    logic unused_fields;

    always_comb begin
        seg_len  = len_word[SEG_LEN_W-1:0];
        seg_last = len_word[END_FLAG_B];
        seg_addr = adr_word[SEG_ADDR_W-1:0];
    end

    assign unused_fields = ^{len_word[END_FLAG_B-1:SEG_LEN_W], adr_word[WORD_W-1:SEG_ADDR_W]};
endmodule

// File: rtl/sgw_seq.sv
module sgw_seq
    import sgw_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int MAX_ENTRIES = 16,
    parameter int IDX_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic [WORD_W-1:0] rsp_data,
    input  logic              out_ready,
    input  logic              cur_last,
    output logic [ADDR_W-1:0] base,
    output logic [IDX_W-1:0]  idx,
    output logic              word_sel,
    output logic [WORD_W-1:0] len_word,
    output logic [WORD_W-1:0] adr_word,
    output logic              req_valid,
    output logic              out_valid,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAX_ENTRIES - 1);

    typedef struct packed {
        walk_state_e       st;
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] len_word;
        logic [WORD_W-1:0] adr_word;
        logic              done;
        logic              err;
    } walk_regs_t;

    walk_regs_t walk_d, walk_q;

    always_comb begin
        walk_d      = walk_q;
        walk_d.done = 1'b0;
        walk_d.err  = 1'b0;
        unique case (walk_q.st)
            WS_IDLE: begin
                if (start) begin
                    walk_d.base = base_in;
                    walk_d.idx  = '0;
                    walk_d.st   = WS_REQ_LEN;
                end
            end
            WS_REQ_LEN: begin
                if (req_ready) walk_d.st = WS_WAIT_LEN;
            end
            WS_WAIT_LEN: begin
                if (rsp_valid) begin
                    walk_d.len_word = rsp_data;
                    walk_d.st       = WS_REQ_ADR;
                end
            end
            WS_REQ_ADR: begin
                if (req_ready) walk_d.st = WS_WAIT_ADR;
            end
            WS_WAIT_ADR: begin
                if (rsp_valid) begin
                    walk_d.adr_word = rsp_data;
                    walk_d.st       = WS_OFFER;
                end
            end
            WS_OFFER: begin
                if (out_ready) begin
                    if (cur_last) begin
                        walk_d.done = 1'b1;
                        walk_d.st   = WS_IDLE;
                    end else if (walk_q.idx == LAST_IDX) begin
                        walk_d.err = 1'b1;
                        walk_d.st  = WS_IDLE;
                    end else begin
                        walk_d.idx = walk_q.idx + 1'b1;
                        walk_d.st  = WS_REQ_LEN;
                    end
                end
            end
            default: walk_d.st = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= '{st: WS_IDLE, default: '0};
        end else begin
            walk_q <= walk_d;
        end
    end

    always_comb begin
        base      = walk_q.base;
        idx       = walk_q.idx;
        len_word  = walk_q.len_word;
        adr_word  = walk_q.adr_word;
        word_sel  = (walk_q.st == WS_REQ_ADR);
        req_valid = (walk_q.st == WS_REQ_LEN) || (walk_q.st == WS_REQ_ADR);
        out_valid = (walk_q.st == WS_OFFER);
        busy      = (walk_q.st != WS_IDLE);
        done      = walk_q.done;
        err       = walk_q.err;
    end
endmodule

// File: rtl/sg_list_walker.sv
module sg_list_walker
    import sgw_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int MAX_ENTRIES = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [ADDR_W-1:0]     base_i,
    output logic                  rd_req_valid_o,
    input  logic                  rd_req_ready_i,
    output logic [ADDR_W-1:0]     rd_addr_o,
    input  logic                  rd_rsp_valid_i,
    input  logic [31:0]           rd_rsp_data_i,
    output logic                  seg_valid_o,
    input  logic                  seg_ready_i,
    output logic [30:0]           seg_addr_o,
    output logic [27:0]           seg_len_o,
    output logic                  seg_last_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  err_o
);
    localparam int IDX_W = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1;

    logic [ADDR_W-1:0] base_w;
    logic [IDX_W-1:0]  idx_w;
    logic              word_sel_w;
    logic [WORD_W-1:0] len_word_w;
    logic [WORD_W-1:0] adr_word_w;
    logic              last_w;

    sgw_seq #(
        .ADDR_W      (ADDR_W),
        .MAX_ENTRIES (MAX_ENTRIES),
        .IDX_W       (IDX_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_i),
        .base_in   (base_i),
        .req_ready (rd_req_ready_i),
        .rsp_valid (rd_rsp_valid_i),
        .rsp_data  (rd_rsp_data_i),
        .out_ready (seg_ready_i),
        .cur_last  (last_w),
        .base      (base_w),
        .idx       (idx_w),
        .word_sel  (word_sel_w),
        .len_word  (len_word_w),
        .adr_word  (adr_word_w),
        .req_valid (rd_req_valid_o),
        .out_valid (seg_valid_o),
        .busy      (busy_o),
        .done      (done_o),
        .err       (err_o)
    );

    sgw_addr_gen #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_addr (
        .base     (base_w),
        .idx      (idx_w),
        .word_sel (word_sel_w),
        .addr     (rd_addr_o)
    );

    sgw_field_split u_split (
        .len_word (len_word_w),
        .adr_word (adr_word_w),
        .seg_len  (seg_len_o),
        .seg_addr (seg_addr_o),
        .seg_last (last_w)
    );

    assign seg_last_o = last_w;
endmodule

// File: rtl/sgw_walk_chk.sv
module sgw_walk_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] base_i,
    input logic              rd_req_valid_o,
    input logic              rd_req_ready_i,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              seg_valid_o,
    input logic              seg_ready_i,
    input logic [30:0]       seg_addr_o,
    input logic [27:0]       seg_len_o,
    input logic              seg_last_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o
);
    // R6
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid_o && !seg_ready_i |=> seg_valid_o && $stable(seg_addr_o)
            && $stable(seg_len_o) && $stable(seg_last_o));

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid_o && !rd_req_ready_i |=> rd_req_valid_o && $stable(rd_addr_o));

    // R5
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(seg_valid_o && seg_ready_i && seg_last_o));

    // R7
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(seg_valid_o && seg_ready_i && !seg_last_o));

    // R5
    end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    // R2
    first_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> rd_req_valid_o && (rd_addr_o == $past(base_i)));
endmodule

bind sg_list_walker sgw_walk_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .base_i         (base_i),
    .rd_req_valid_o (rd_req_valid_o),
    .rd_req_ready_i (rd_req_ready_i),
    .rd_addr_o      (rd_addr_o),
    .seg_valid_o    (seg_valid_o),
    .seg_ready_i    (seg_ready_i),
    .seg_addr_o     (seg_addr_o),
    .seg_len_o      (seg_len_o),
    .seg_last_o     (seg_last_o),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .err_o          (err_o)
);

// File: tb/sim_sg_list_walker.sv
`timescale 1ns/1ps
module sim_sg_list_walker;
    localparam int AW  = 32;
    localparam int MAXE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [AW-1:0] base_i = '0;
    logic rd_req_valid_o, rd_req_ready_i = 1'b0;
    logic [AW-1:0] rd_addr_o;
    logic rd_rsp_valid_i = 1'b0;
    logic [31:0] rd_rsp_data_i = '0;
    logic seg_valid_o, seg_ready_i = 1'b0;
    logic [30:0] seg_addr_o;
    logic [27:0] seg_len_o;
    logic seg_last_o, busy_o, done_o, err_o;

    always #10 clk = ~clk;

    sg_list_walker #(.ADDR_W(AW), .MAX_ENTRIES(MAXE)) u0 (.*);

    logic [31:0] mem [0:255];
    logic [31:0] exp_rd_q[$];
    logic [27:0] exp_len_q[$];
    logic [30:0] exp_adr_q[$];
    logic        exp_last_q[$];
    logic        exp_fin_q[$];

    int checks = 0, fails = 0, cyc = 0;
    bit run = 0, model_busy = 0, exp_done = 0, exp_err = 0, finished = 0;
    int rr_mode = 0, sr_mode = 0, lat_mode = 0;
    bit rsp_pend = 0; int rsp_cnt = 0; logic [31:0] rsp_word = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Reference list decode: descriptor k at base+8k, len word first
    function automatic void build(input logic [31:0] b);
        for (int k = 0; k < MAXE; k++) begin
            logic [31:0] la, lw, aw;
            la = b + 32'(8 * k);
            lw = mem[la[9:2]];
            aw = mem[(la + 32'd4) >> 2 & 32'hFF];
            exp_rd_q.push_back(la);
            exp_rd_q.push_back(la + 32'd4);
            exp_len_q.push_back(lw[27:0]);
            exp_adr_q.push_back(aw[30:0]);
            exp_last_q.push_back(lw[31]);
            exp_fin_q.push_back(lw[31] || (k == MAXE - 1));
            if (lw[31]) break;
        end
    endfunction

    function automatic bit pat(input int mode);
        return (mode == 0) ? 1'b1 : ((cyc % mode) != 0);
    endfunction

    always @(negedge clk) begin
        if (run) begin
            bit rr, sr;
            cyc++;
            if (done_o || exp_done) chk(done_o == exp_done, "R5 done pulse", 32'(done_o), 32'(exp_done));
            if (err_o || exp_err)   chk(err_o == exp_err, "R7 err pulse", 32'(err_o), 32'(exp_err));
            if (exp_done || exp_err) begin
                chk(!busy_o, "R5 idle at end", 32'(busy_o), 0);
                model_busy = 0;
            end
            exp_done = 0; exp_err = 0;
            // response channel
            rd_rsp_valid_i = 1'b0;
            if (rsp_pend) begin
                if (rsp_cnt == 0) begin
                    rd_rsp_valid_i = 1'b1; rd_rsp_data_i = rsp_word; rsp_pend = 0;
                end else rsp_cnt--;
            end
            // request channel
            rr = pat(rr_mode);
            rd_req_ready_i = rr;
            if (rd_req_valid_o) begin
                chk(!seg_valid_o, "R6 no read while record held", 32'(seg_valid_o), 0);
                if (exp_rd_q.size() == 0) begin
                    chk(0, "R7/R9 unexpected read", rd_addr_o, 0);
                end else begin
                    chk(rd_addr_o == exp_rd_q[0], "R2 read address", rd_addr_o, exp_rd_q[0]);
                    if (rr) begin
                        rsp_word = mem[rd_addr_o[9:2]];
                        void'(exp_rd_q.pop_front());
                        rsp_pend = 1; rsp_cnt = lat_mode ? (cyc % 3) : 0;
                    end
                end
            end
            // record channel
            sr = pat(sr_mode);
            seg_ready_i = sr;
            if (seg_valid_o) begin
                if (exp_len_q.size() == 0) chk(0, "R6 unexpected record", 32'(seg_len_o), 0);
                else begin
                    chk(seg_len_o == exp_len_q[0], "R3 length field", 32'(seg_len_o), 32'(exp_len_q[0]));
                    chk(seg_addr_o == exp_adr_q[0], "R4 address field", 32'(seg_addr_o), 32'(exp_adr_q[0]));
                    chk(seg_last_o == exp_last_q[0], "R5 last flag", 32'(seg_last_o), 32'(exp_last_q[0]));
                    if (sr) begin
                        if (exp_fin_q[0]) begin
                            if (exp_last_q[0]) exp_done = 1; else exp_err = 1;
                        end
                        void'(exp_len_q.pop_front()); void'(exp_adr_q.pop_front());
                        void'(exp_last_q.pop_front()); void'(exp_fin_q.pop_front());
                    end
                end
            end
        end
    end

    task automatic kick(input logic [31:0] b);
        @(negedge clk);
        start_i = 1'b1; base_i = b;
        if (!model_busy) begin model_busy = 1; build(b); end
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (model_busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(exp_rd_q.size() == 0 && exp_len_q.size() == 0, "R2 walk consumed",
            32'(exp_rd_q.size() + exp_len_q.size()), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'(i) * 32'h0101_0103;
        // list A @0x040: three entries, last on third; junk in 30:28 and bit 31
        mem[8'h10] = 32'h7000_0010; mem[8'h11] = 32'h8000_1234;
        mem[8'h12] = 32'h0ABC_DEF0; mem[8'h13] = 32'hFFFF_FFFC;
        mem[8'h14] = 32'h8000_0044; mem[8'h15] = 32'h0000_0100;
        // list B @0x100: single last entry
        mem[8'h40] = 32'hFFFF_FFFF; mem[8'h41] = 32'h1234_5678;
        // list C @0x200: six entries, none last
        for (int i = 0; i < 12; i++) mem[8'h80 + i] = 32'h4000_0000 | 32'(i * 16);
        // list D @0x300: last exactly at entry MAXE-1
        for (int i = 0; i < 8; i++) mem[8'hC0 + i] = 32'h0000_0200 + 32'(i);
        mem[8'hC6] = 32'h8000_0020;

        repeat (3) @(negedge clk);
        // R1 during reset
        chk(!busy_o && !rd_req_valid_o && !seg_valid_o && !done_o && !err_o, "R1 reset state",
            {27'd0, busy_o, rd_req_valid_o, seg_valid_o, done_o, err_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !rd_req_valid_o && !seg_valid_o && !done_o && !err_o, "R1 after reset",
            {27'd0, busy_o, rd_req_valid_o, seg_valid_o, done_o, err_o}, 0);
        run = 1;

        kick(32'h040); wait_idle();                        // R2 R3 R4 R5
        kick(32'h100); wait_idle();                        // R5 single entry
        kick(32'h200); wait_idle();                        // R7 limit reached
        kick(32'h300); wait_idle();                        // R5 last at limit boundary
        rr_mode = 3; sr_mode = 2; lat_mode = 1;            // R6 R9 stalls
        kick(32'h040);
        repeat (5) @(negedge clk);
        kick(32'h300);                                     // R8 start while busy ignored
        wait_idle();
        rr_mode = 2; sr_mode = 4;
        kick(32'h200); wait_idle();                        // R7 under stalls
        kick(32'h100); wait_idle();

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule